// File: doc/BRIEF.md
# Mailbox Boot Upload Receiver

This block is the receiving end of a byte-serial program upload carried over four 8-bit mailbox ports shared with a host processor. Coming out of reset it first zeroes the lowest 240 bytes of local memory. It then posts a ready pattern on its outgoing ports and waits for the host to send a start code. On that code it latches a 16-bit destination from the two upper ports and echoes the code back.

A control byte then picks the next step. A zero control byte makes the block raise a sticky launch signal carrying the destination. Any other value starts a counted stream. Each byte is accepted when the host's sequence number on port 0 matches an internal 8-bit counter. The byte goes to memory at an incrementing address, and the sequence number is echoed as an acknowledge. A sequence number that jumps past the counter closes the block. The block then latches a fresh destination and applies the same control-byte choice again, so a whole image can be loaded as several blocks before execution starts.

Top module: `boot_upload_rx`

## Requirements
- R1: After reset, before anything else, the block writes 0x00 to addresses 0x0000 through 0x00EF, one write per cycle in ascending order.
- R2: When the clear is done, outgoing port 0 shows 0xAA and outgoing port 1 shows 0xBB. Outgoing ports 2 and 3 always show 0x00.
- R3: Before the start code arrives, any incoming port 0 value other than 0xCC is ignored. No memory write happens and outgoing port 0 keeps 0xAA.
- R4: When incoming port 0 equals 0xCC, the block latches the destination as {port 3, port 2} (port 3 is the high byte) and echoes 0xCC on outgoing port 0.
- R5: If incoming port 1 is 0x00 when the destination is latched, exec_go rises and exec_addr carries that destination.
- R6: If incoming port 1 is nonzero at that point, the block waits for incoming port 0 to read 0x00. It then writes port 1's value to the destination, echoes 0x00 and sets its counter to 1.
- R7: While streaming, incoming port 0 equal to the counter writes port 1's value to the next address, echoes the value, and increments both the address and the counter. Address carry crosses 8-bit page boundaries.
- R8: While streaming, an incoming port 0 value below the counter (unsigned 8-bit) is ignored. No write happens and outgoing port 0 is unchanged.
- R9: While streaming, an incoming port 0 value above the counter echoes that value and writes nothing. The block latches a new destination from ports 3 and 2 and applies R5/R6 using port 1.
- R10: Once exec_go is high it stays high with exec_addr unchanged, and no further memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_p0 | input | 8 | Incoming mailbox port 0 (start code / sequence number) |
| host_p1 | input | 8 | Incoming mailbox port 1 (control / data byte) |
| host_p2 | input | 8 | Incoming mailbox port 2 (destination low byte) |
| host_p3 | input | 8 | Incoming mailbox port 3 (destination high byte) |
| reply_p0 | output | 8 | Outgoing port 0 (ready pattern / acknowledge echo) |
| reply_p1 | output | 8 | Outgoing port 1 (ready pattern) |
| reply_p2 | output | 8 | Outgoing port 2, held at zero |
| reply_p3 | output | 8 | Outgoing port 3, held at zero |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| exec_go | output | 1 | Start-execution request, sticky |
| exec_addr | output | 16 | Jump address for execution |

## Verification
On every cycle the assertions check several relations between control events and registered outputs. Clear events must yield zero-data writes at the clear index. The ready event must yield the two ready bytes. Captures must echo port 0 and latch {port 3, port 2}, and accepted bytes must land at the current destination. A sequence number below the counter must trigger nothing, and the launch must be sticky with no writes after it. Only the bench's host scenarios can show the whole exchange. These cover ignored values before the start code and during a stream, a block that crosses a page boundary, the return for a second block, the final jump address, and the resulting memory image.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_READY,
    ST_WAIT_START,
    ST_WAIT_ZERO,
    ST_STREAM,
    ST_EXEC
  } ld_state_e;

  // sequence number matches the expected count: accept a byte
  function automatic logic seq_hit(input logic [PORT_W-1:0] seq,
                                   input logic [PORT_W-1:0] cnt);
    return seq == cnt;
  endfunction

  // sequence number jumped ahead (unsigned): close the block
  function automatic logic seq_skip(input logic [PORT_W-1:0] seq,
                                    input logic [PORT_W-1:0] cnt);
    return seq > cnt;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PORT_W-1:0] hi,
                                                  input logic [PORT_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/bootld_ctrl.sv
module bootld_ctrl
  import bootld_pkg::*;
#(
  parameter logic [PORT_W-1:0] START_CODE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] host_p0,
  input  logic [PORT_W-1:0] host_p1,
  input  logic [PORT_W-1:0] cnt,
  input  logic              clr_done,
  output logic              ev_clear,
  output logic              ev_ready,
  output logic              ev_capture,
  output logic              ev_launch,
  output logic              ev_write,
  output logic              ev_first
);
  ld_state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_CLEAR;
    else        state <= nxt;
  end

  always_comb begin
    nxt        = state;
    ev_clear   = 1'b0;
    ev_ready   = 1'b0;
    ev_capture = 1'b0;
    ev_write   = 1'b0;
    ev_first   = 1'b0;
    case (state)
      ST_CLEAR: begin
        ev_clear = 1'b1;
        if (clr_done) nxt = ST_READY;
      end
      ST_READY: begin
        ev_ready = 1'b1;
        nxt      = ST_WAIT_START;
      end
      ST_WAIT_START: begin
        if (host_p0 == START_CODE) ev_capture = 1'b1;
      end
      ST_WAIT_ZERO: begin
        if (host_p0 == '0) begin
          ev_write = 1'b1;
          ev_first = 1'b1;
          nxt      = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (seq_hit(host_p0, cnt))       ev_write   = 1'b1;
        else if (seq_skip(host_p0, cnt)) ev_capture = 1'b1;
      end
      default: nxt = ST_EXEC;
    endcase
    ev_launch = ev_capture && (host_p1 == '0);
    if (ev_capture) nxt = (host_p1 == '0) ? ST_EXEC : ST_WAIT_ZERO;
  end

  // R8: a lagging sequence number in a stream triggers nothing
  a_r8_lag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM && host_p0 < cnt) |-> (!ev_write && !ev_capture));

  // R10: the launch state is final
  a_r10_exec_final: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |=> (state == ST_EXEC));
endmodule

// File: rtl/bootld_datapath.sv
module bootld_datapath
  import bootld_pkg::*;
#(
  parameter logic [PORT_W-1:0] CLR_LAST = 8'hEF,
  parameter logic [PORT_W-1:0] RDY0     = 8'hAA,
  parameter logic [PORT_W-1:0] RDY1     = 8'hBB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] host_p0,
  input  logic [PORT_W-1:0] host_p1,
  input  logic [PORT_W-1:0] host_p2,
  input  logic [PORT_W-1:0] host_p3,
  input  logic              ev_clear,
  input  logic              ev_ready,
  input  logic              ev_capture,
  input  logic              ev_launch,
  input  logic              ev_write,
  input  logic              ev_first,
  output logic [PORT_W-1:0] cnt,
  output logic              clr_done,
  output logic [PORT_W-1:0] reply0,
  output logic [PORT_W-1:0] reply1,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PORT_W-1:0] mem_wdata,
  output logic              exec_go,
  output logic [ADDR_W-1:0] exec_addr
);
  logic [PORT_W-1:0] clr_idx;
  logic [ADDR_W-1:0] dest;
  logic [ADDR_W-1:0] host_dest;

  assign clr_done  = (clr_idx == CLR_LAST);
  assign host_dest = join_addr(host_p3, host_p2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_idx   <= '0;
      dest      <= '0;
      cnt       <= '0;
      reply0    <= '0;
      reply1    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      exec_go   <= 1'b0;
      exec_addr <= '0;
    end else begin
      mem_we <= 1'b0;
      if (ev_clear) begin
        mem_we    <= 1'b1;
        mem_addr  <= ADDR_W'(clr_idx);
        mem_wdata <= '0;
        clr_idx   <= clr_idx + 1'b1;
      end
      if (ev_ready) begin
        reply0 <= RDY0;
        reply1 <= RDY1;
      end
      if (ev_capture) begin
        dest   <= host_dest;
        reply0 <= host_p0;
      end
      if (ev_launch) begin
        exec_go   <= 1'b1;
        exec_addr <= host_dest;
      end
      if (ev_write) begin
        mem_we    <= 1'b1;
        mem_addr  <= dest;
        mem_wdata <= host_p1;
        reply0    <= host_p0;
        dest      <= dest + 1'b1;
        cnt       <= ev_first ? PORT_W'(1) : cnt + 1'b1;
      end
    end
  end

  // R1: each clear step lands as a zero write at the running index
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (mem_we && mem_wdata == '0 && mem_addr == ADDR_W'($past(clr_idx))));

  // R2: ready pattern follows the ready event
  a_r2_ready_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> (reply0 == RDY0 && reply1 == RDY1));

  // R4: capture echoes port 0 and latches {p3,p2}
  a_r4_capture_echo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (reply0 == $past(host_p0) && dest == {$past(host_p3), $past(host_p2)}));

  // R7: accepted byte is written at the current destination
  a_r7_byte_store: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (mem_we && mem_wdata == $past(host_p1) && mem_addr == $past(dest)));

  // R10: launch is sticky, stable and silent
  a_r10_exec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> (exec_go && $stable(exec_addr) && !mem_we));
endmodule

// File: rtl/boot_upload_rx.sv
module boot_upload_rx
  import bootld_pkg::*;
#(
  parameter logic [7:0] CLR_LAST   = 8'hEF,
  parameter logic [7:0] RDY0       = 8'hAA,
  parameter logic [7:0] RDY1       = 8'hBB,
  parameter logic [7:0] START_CODE = 8'hCC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  host_p0,
  input  logic [7:0]  host_p1,
  input  logic [7:0]  host_p2,
  input  logic [7:0]  host_p3,
  output logic [7:0]  reply_p0,
  output logic [7:0]  reply_p1,
  output logic [7:0]  reply_p2,
  output logic [7:0]  reply_p3,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        exec_go,
  output logic [15:0] exec_addr
);
  logic              ev_clear, ev_ready, ev_capture, ev_launch, ev_write, ev_first;
  logic              clr_done;
  logic [PORT_W-1:0] cnt;

  bootld_ctrl #(.START_CODE(START_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_p0(host_p0), .host_p1(host_p1),
    .cnt(cnt), .clr_done(clr_done),
    .ev_clear(ev_clear), .ev_ready(ev_ready), .ev_capture(ev_capture),
    .ev_launch(ev_launch), .ev_write(ev_write), .ev_first(ev_first)
  );

  bootld_datapath #(.CLR_LAST(CLR_LAST), .RDY0(RDY0), .RDY1(RDY1)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .host_p0(host_p0), .host_p1(host_p1), .host_p2(host_p2), .host_p3(host_p3),
    .ev_clear(ev_clear), .ev_ready(ev_ready), .ev_capture(ev_capture),
    .ev_launch(ev_launch), .ev_write(ev_write), .ev_first(ev_first),
    .cnt(cnt), .clr_done(clr_done),
    .reply0(reply_p0), .reply1(reply_p1),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .exec_go(exec_go), .exec_addr(exec_addr)
  );

  assign reply_p2 = '0;
  assign reply_p3 = '0;

  // R2: upper reply ports stay zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_p2 == 8'h00 && reply_p3 == 8'h00));
endmodule

// File: tb/boot_upload_rx_bench.sv
module boot_upload_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_p0 = '0, host_p1 = '0, host_p2 = '0, host_p3 = '0;
  logic [7:0]  reply_p0, reply_p1, reply_p2, reply_p3;
  logic        mem_we, exec_go;
  logic [15:0] mem_addr, exec_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  shadow [int];
  logic [7:0]  blk1 [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
  logic [7:0]  blk2 [4] = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};

  always #4 clk = ~clk;

  boot_upload_rx u_boot_upload_rx (
    .clk(clk), .rst_n(rst_n),
    .host_p0(host_p0), .host_p1(host_p1), .host_p2(host_p2), .host_p3(host_p3),
    .reply_p0(reply_p0), .reply_p1(reply_p1), .reply_p2(reply_p2), .reply_p3(reply_p3),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .exec_go(exec_go), .exec_addr(exec_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R8/R10 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R1/R6/R7 write", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
      end
      shadow[int'(mem_addr)] = mem_wdata;
    end
  end

  task automatic wait_reply(input logic [7:0] v, input string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (reply_p0 == v) break;
    end
    chk(reply_p0 == v, req, {24'h0, reply_p0}, {24'h0, v});
  endtask

  task automatic send_byte(input logic [15:0] a, input logic [7:0] d, input logic [7:0] seq, input string req);
    @(negedge clk);
    exp_q.push_back({a, d});
    host_p1 = d;
    host_p0 = seq;
    wait_reply(seq, req);
  endtask

  task automatic hold_check(input logic [7:0] v, input string req);
    repeat (5) @(negedge clk);
    chk(reply_p0 == v, req, {24'h0, reply_p0}, {24'h0, v});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reply_p0 == 8'h00 && !mem_we && !exec_go, "reset state", {reply_p0, 7'h0, mem_we, 7'h0, exec_go}, 32'h0);
    for (int i = 0; i <= 8'hEF; i++) exp_q.push_back({16'(i), 8'h00}); // R1
    rst_n = 1'b1;
    wait_reply(8'hAA, "R2 ready p0");
    chk(exp_q.size() == 0, "R1 clear done before ready", exp_q.size(), 0);
    chk(reply_p1 == 8'hBB, "R2 ready p1", {24'h0, reply_p1}, 32'hBB);
    chk(reply_p2 == 8'h00 && reply_p3 == 8'h00, "R2 upper zero", {16'h0, reply_p2, reply_p3}, 0);

    // R3: non-start values ignored
    host_p0 = 8'h12; host_p1 = 8'h05;
    hold_check(8'hAA, "R3 ignore before start");

    // R4: start block 1 at 0x0200
    host_p2 = 8'h00; host_p3 = 8'h02; host_p1 = 8'h01; host_p0 = 8'hCC;
    wait_reply(8'hCC, "R4 start echo");
    hold_check(8'hCC, "R6 wait for zero");

    for (int k = 0; k < 5; k++) begin
      send_byte(16'h0200 + 16'(k), blk1[k], 8'(k), k == 0 ? "R6 first byte" : "R7 next byte");
      if (k == 3) begin
        host_p0 = 8'h01;
        hold_check(8'h03, "R8 lagging seq ignored");
      end
    end

    // R9: jump ahead closes block, new dest 0x30FE
    @(negedge clk);
    host_p2 = 8'hFE; host_p3 = 8'h30; host_p1 = 8'h07; host_p0 = 8'h06;
    wait_reply(8'h06, "R9 block end echo");
    hold_check(8'h06, "R9 no write at block end");

    for (int k = 0; k < 4; k++)
      send_byte(16'h30FE + 16'(k), blk2[k], 8'(k), "R7 page crossing");

    // R5: final jump to 0x0234
    @(negedge clk);
    host_p2 = 8'h34; host_p3 = 8'h02; host_p1 = 8'h00; host_p0 = 8'h05;
    wait_reply(8'h05, "R9 final echo");
    @(negedge clk);
    chk(exec_go == 1'b1, "R5 exec_go", {31'h0, exec_go}, 1);
    chk(exec_addr == 16'h0234, "R5 exec_addr", {16'h0, exec_addr}, 32'h0234);

    // R10: stays launched and silent
    host_p0 = 8'h06; host_p1 = 8'h99;
    repeat (8) @(negedge clk);
    host_p0 = 8'h00;
    repeat (8) @(negedge clk);
    chk(exec_go && exec_addr == 16'h0234, "R10 sticky launch", {15'h0, exec_go, exec_addr}, {15'h0, 1'b1, 16'h0234});

    // memory image
    for (int k = 0; k < 5; k++)
      chk(shadow.exists(32'h0200 + k) && shadow[32'h0200 + k] == blk1[k], "R7 image block 1",
          shadow.exists(32'h0200 + k) ? {24'h0, shadow[32'h0200 + k]} : 32'hFFFF, {24'h0, blk1[k]});
    for (int k = 0; k < 4; k++)
      chk(shadow.exists(32'h30FE + k) && shadow[32'h30FE + k] == blk2[k], "R7 image block 2",
          shadow.exists(32'h30FE + k) ? {24'h0, shadow[32'h30FE + k]} : 32'hFFFF, {24'h0, blk2[k]});
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule